// File: doc/BRIEF.md
# Dual-Edge XOR Serializer

This block doubles the bit rate of a design that runs from a single clock. Every clock cycle it takes one two-bit symbol per output lane from the parallel datapath. It then drives that lane's pin with both bits inside the same clock period: the lead bit is on the pin while the clock is high, and the trail bit is on the pin while the clock is low. With a 250 MHz core clock, this gives 500 Msamples/s per pin.

Each lane has two storage paths. One register updates on the rising clock edge and one updates on the falling edge. The pin is the XOR of the two registers. Each register stores its new bit already XORed with the current state of the other register, so the XOR at the pin gives back the wanted bit. The pin is never fed through a multiplexer whose select is the clock. The trail bit is captured at the rising edge into a holding register. This means the falling-edge path only ever reads a value that has been stable for half a period.

Top module: `dx_serializer`

## Requirements
- R1: While `rst_n` is low, every bit of `dout_o` is 0, and asserting `rst_n` clears the lanes asynchronously, including in the middle of a clock phase.
- R2: During the high phase that follows a rising edge, `dout_o[k]` equals bit `2k` (the lead bit) of the `sym_i` value sampled at that rising edge.
- R3: During the low phase that follows, `dout_o[k]` equals bit `2k+1` (the trail bit) of the `sym_i` value sampled at the preceding rising edge.
- R4: A change on `sym_i` after a rising edge has no effect on `dout_o` in either phase of that clock cycle. Both bits of a symbol come from the single rising-edge sample.
- R5: Each lane `k` depends only on `sym_i[2k+1:2k]`, for every combination of the symbol before and the symbol after.
- R6: After reset, while `sym_i` is held at zero, `dout_o` stays 0 in both phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; both of its edges advance the output |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 2*LANES | Symbols; lane k uses bit 2k as lead (high phase) and bit 2k+1 as trail (low phase) |
| dout_o | output | LANES | Serial output, one pin per lane, two bits per clock period |

## Verification
The bench builds the block with two lanes, so each symbol word is only four bits wide. This small width lets every ordered pair of consecutive words, 256 transitions in all, be driven. Each output bit is the XOR of two registers, and each register stores data XORed against the other register's previous state. Because every pair is driven, every combination of prior register state and new data reaches both lanes, with the neighbouring lane changing alongside. The bench also changes the input just after a rising edge and applies reset in the middle of a phase, so that the single-sample rule and the asynchronous clear are both observed at the pins.

// File: rtl/dx_pkg.sv
package dx_pkg;

    // State captured on the rising edge for one lane
    typedef struct packed {
        logic rise;   // pre-encoded lead bit
        logic hold;   // trail bit held for the falling-edge path
    } dx_rise_t;

    // State captured on the falling edge for one lane
    typedef struct packed {
        logic fall;   // pre-encoded trail bit
    } dx_fall_t;

    // Bit offsets of a lane symbol inside the input word
    localparam int unsigned DX_LEAD_OFS  = 0;
    localparam int unsigned DX_TRAIL_OFS = 1;
    localparam int unsigned DX_SYM_BITS  = 2;

endpackage

// File: rtl/dx_rise_stage.sv
module dx_rise_stage
    import dx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lead_i,
    input  logic trail_i,
    input  logic fall_i,
    output logic rise_o,
    output logic hold_o
);

    dx_rise_t st_d;
    dx_rise_t st_q;

    // Pre-encode the lead bit against the falling register so the XOR
    // at the pin reproduces it during the high phase.
    always_comb begin
        st_d      = st_q;
        st_d.rise = lead_i ^ fall_i;
        st_d.hold = trail_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.rise;
    assign hold_o = st_q.hold;

endmodule

// File: rtl/dx_fall_stage.sv
module dx_fall_stage
    import dx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic rise_i,
    output logic fall_o
);

    dx_fall_t st_d;
    dx_fall_t st_q;

    // Pre-encode the held trail bit against the rising register so the
    // XOR at the pin reproduces it during the low phase.
    always_comb begin
        st_d      = st_q;
        st_d.fall = hold_i ^ rise_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.fall;

endmodule

// File: rtl/dx_lane.sv
module dx_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sym_i,
    output logic       dout_o
);

    logic rise_w;
    logic hold_w;
    logic fall_w;

    dx_rise_stage u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .lead_i  (sym_i[dx_pkg::DX_LEAD_OFS]),
        .trail_i (sym_i[dx_pkg::DX_TRAIL_OFS]),
        .fall_i  (fall_w),
        .rise_o  (rise_w),
        .hold_o  (hold_w)
    );

    dx_fall_stage u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (hold_w),
        .rise_i (rise_w),
        .fall_o (fall_w)
    );

    // Both inputs of this gate are register outputs: no clock in the data path
    assign dout_o = rise_w ^ fall_w;

endmodule

// File: rtl/dx_serializer.sv
module dx_serializer #(
    parameter int unsigned LANES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [LANES*dx_pkg::DX_SYM_BITS-1:0]   sym_i,
    output logic [LANES-1:0]                       dout_o
);

    localparam int unsigned SYM_W = dx_pkg::DX_SYM_BITS;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dx_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .sym_i  (sym_i[k*SYM_W +: SYM_W]),
            .dout_o (dout_o[k])
        );
    end

endmodule

// File: rtl/dx_serializer_chk.sv
module dx_serializer_chk #(
    parameter int unsigned LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES*2-1:0]     sym_i,
    input logic [LANES-1:0]       dout_o
);

    logic [LANES*2-1:0] cap_q;
    logic [LANES-1:0]   lead_w;
    logic [LANES-1:0]   trail_w;

    // Checker-side copy of the symbol seen at the last rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= sym_i;
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            lead_w[k]  = cap_q[2*k];
            trail_w[k] = cap_q[2*k+1];
        end
    end

    // R1: reset holds every pin low
    a_r1_reset_low: assert property (@(negedge clk) !rst_n |-> (dout_o == '0));

    // R2: value present through the high phase is the lead bit
    a_r2_high_lead: assert property (@(negedge clk) disable iff (!rst_n)
        dout_o == lead_w);

    // R3: value present through the low phase is the trail bit
    a_r3_low_trail: assert property (@(posedge clk) disable iff (!rst_n)
        dout_o == trail_w);

    // R6: an all-zero captured symbol leaves the pins low
    a_r6_zero_idle: assert property (@(negedge clk) disable iff (!rst_n)
        (cap_q == '0) |-> (dout_o == '0));

endmodule

bind dx_serializer dx_serializer_chk #(.LANES(LANES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sym_i  (sym_i),
    .dout_o (dout_o)
);

// File: tb/sim_dx_serializer.sv
`timescale 1ps/1ps
module sim_dx_serializer;

    localparam int LANES = 2;
    localparam int HALF  = 2500;   // 200 MHz clock
    localparam int QTR   = HALF / 2;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       sym   = '0;
    logic [LANES-1:0] dout;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #HALF clk = ~clk;

    dx_serializer #(.LANES(LANES)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sym_i  (sym),
        .dout_o (dout)
    );

    function automatic logic [1:0] lead_of(input logic [3:0] s);
        return {s[2], s[0]};
    endfunction

    function automatic logic [1:0] trail_of(input logic [3:0] s);
        return {s[3], s[1]};
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Present s before the rising edge; optionally disturb the input after it.
    task automatic run_cycle(input logic [3:0] s, input bit disturb, input string rh, input string rl);
        sym = s;
        @(posedge clk);
        if (disturb) begin
            #200;
            sym = ~s;
        end
        #(QTR - (disturb ? 200 : 0));
        chk(rh, dout, lead_of(s));
        @(negedge clk);
        #QTR;
        chk(rl, dout, trail_of(s));
    endtask

    initial begin
        // R1: reset dominates a non-zero input
        sym = 4'hF;
        repeat (2) begin
            @(posedge clk); #QTR; chk("R1 high", dout, 2'b00);
            @(negedge clk); #QTR; chk("R1 low",  dout, 2'b00);
        end
        rst_n = 1'b1;
        // R6: zero input after reset keeps pins low
        for (int i = 0; i < 4; i++) run_cycle(4'h0, 1'b0, "R6 high", "R6 low");
        // R2 R3 R5: every ordered pair of consecutive symbols
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                run_cycle(a[3:0], 1'b0, "R2 R5 lead", "R3 R5 trail");
                run_cycle(b[3:0], 1'b0, "R2 R5 lead", "R3 R5 trail");
            end
        end
        // R4: input flipped just after the rising edge is ignored
        for (int a = 0; a < 16; a++) run_cycle(a[3:0], 1'b1, "R4 lead", "R4 trail");
        // R1: asynchronous clear in the middle of a high phase
        sym = 4'hF;
        @(posedge clk); #QTR;
        chk("R1 pre", dout, 2'b11);
        rst_n = 1'b0;
        #10;
        chk("R1 async", dout, 2'b00);
        @(negedge clk); #QTR; chk("R1 held", dout, 2'b00);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) run_cycle(a[3:0], 1'b0, "R2 resume", "R3 resume");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20000 * 2 * HALF);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule